// File: doc/BRIEF.md
# Serial Transmitter with One-Byte Holding Register

This block sends bytes over an asynchronous serial line. Software writes a byte into a one-entry holding register. When transmission is enabled and a baud tick arrives while the shifter is idle, the held byte moves into the frame shifter. The block then sends a low start bit, the data bits least significant first, one optional extra bit, and a high stop bit. Every bit lasts exactly one baud period. The baud period is the interval between single-cycle pulses on `baud_tick`. Baud generation lives outside the block.

The extra bit depends on the mode. In normal mode it is an optional even or odd parity bit. In multiprocessor mode it is an address/data marker supplied by software, and the data length is fixed at eight bits. The empty flag rises as soon as the held byte enters the shifter, not when the frame ends. Software can therefore queue the next byte during the current frame, and frames then follow each other with no idle gap. The interrupt request is the empty flag gated by an enable input.

Top module: `uart_tx_hold`

## Requirements
- R1: After reset `txd` is 1 and `tdre` is 1.
- R2: A write (`wr_en`=1) makes `tdre` 0 at the next clock edge. `tdre` stays 0 until the byte moves into the shifter.
- R3: A frame is a 0 start bit, then the data LSB first, then a 1 stop bit. `txd` changes only at a clock edge where `baud_tick` was 1, so each bit lasts one baud period.
- R4: In normal mode (`mp_mode`=0), `len8`=1 sends 8 data bits and `len8`=0 sends 7 data bits (`wr_data[6:0]`).
- R5: In normal mode with `par_en`=1, one parity bit follows the data. With `par_odd`=0 it is the XOR of the sent data bits (even). With `par_odd`=1 it is the inverse (odd). With `par_en`=0 no bit is added.
- R6: In multiprocessor mode (`mp_mode`=1), 8 data bits are sent whatever `len8` is, and `par_en` is ignored. The data is followed by the value that `adr_bit` had at the tick the frame started. Later changes to `adr_bit` do not affect that frame.
- R7: `tdre` becomes 1 at the same edge where the start bit appears on `txd`.
- R8: `tx_irq` is 1 exactly when `tdre` is 1 and `tie` is 1.
- R9: If a byte is held when the stop bit's period ends, the next start bit is driven at that same tick, with no idle period.
- R10: While `tx_en` is 0, no frame starts. `txd` stays 1 and the held byte waits with `tdre` at 0 until a tick arrives with `tx_en` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| tx_en | input | 1 | Transmission enable |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| mp_mode | input | 1 | 1 = multiprocessor mode, 0 = normal mode |
| len8 | input | 1 | Normal mode data length: 1 = 8 bits, 0 = 7 bits |
| par_en | input | 1 | Normal mode parity enable |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| adr_bit | input | 1 | Address/data marker for multiprocessor frames |
| tie | input | 1 | Transmit interrupt enable |
| txd | output | 1 | Serial output, idles high |
| tdre | output | 1 | Holding register empty flag |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
`tdre` reacts one edge after a write. The start bit and the rise of `tdre` appear together at the edge that samples the load tick. Every later bit appears one edge after its own tick. `tx_irq` follows `tdre` in the same cycle.

The bench drives all inputs on falling edges. Each tick lasts one cycle and is followed by two idle cycles. The bench samples only after that wait, so each sample shows a settled bit that has also held across idle cycles. The expected bit for tick number k is computed from the frame rules. The bench checks 13 ticks per frame, so the idle level after the stop bit is also checked.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    localparam int unsigned DW  = 8;
    localparam int unsigned FW  = DW + 3;
    localparam int unsigned CW  = $clog2(FW + 1);

    typedef struct packed {
        logic mp;
        logic len8;
        logic par_en;
        logic par_odd;
    } tx_cfg_t;

    function automatic logic parity_of(input logic [DW-1:0] d, input logic full_len,
                                       input logic odd);
        logic [DW-1:0] m;
        m = d;
        if (!full_len) m[DW-1] = 1'b0;
        return (^m) ^ odd;
    endfunction
endpackage

// File: rtl/uart_tx_holdreg.sv
module uart_tx_holdreg
    import uart_tx_pkg::*;
#(
    parameter int unsigned WIDTH = DW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             take,
    output logic             full,
    output logic [WIDTH-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else if (wr_en) begin
            full <= 1'b1;
            data <= wr_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          baud_tick,
    input  logic          tx_en,
    input  logic          held,
    input  logic [DW-1:0] held_data,
    input  tx_cfg_t       cfg,
    input  logic          adr_bit,
    output logic          take,
    output logic          txd
);
    logic [FW-1:0] frame;
    logic [CW-1:0] nbits;
    logic [FW-1:0] sh_q;
    logic [CW-1:0] left_q;
    logic          txd_q;
    int unsigned   dbits;
    logic          extra;

    always_comb begin
        dbits = (cfg.mp || cfg.len8) ? DW : DW - 1;
        extra = cfg.mp || cfg.par_en;
        frame = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DW; i++) begin
            if (i < dbits) frame[1+i] = held_data[i];
        end
        if (cfg.mp)          frame[1+dbits] = adr_bit;
        else if (cfg.par_en) frame[1+dbits] = parity_of(held_data, cfg.len8, cfg.par_odd);
        nbits = CW'(dbits + 2 + (extra ? 1 : 0));
    end

    assign take = baud_tick && (left_q == '0) && held && tx_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '1;
            left_q <= '0;
            txd_q  <= 1'b1;
        end else if (baud_tick) begin
            if (left_q == '0) begin
                if (take) begin
                    txd_q  <= frame[0];
                    sh_q   <= {1'b1, frame[FW-1:1]};
                    left_q <= nbits - 1'b1;
                end else begin
                    txd_q  <= 1'b1;
                end
            end else begin
                txd_q  <= sh_q[0];
                sh_q   <= {1'b1, sh_q[FW-1:1]};
                left_q <= left_q - 1'b1;
            end
        end
    end

    assign txd = txd_q;

    a_r3_bits_on_tick: assert property (@(posedge clk) disable iff (rst)
        (txd_q != $past(txd_q)) |-> $past(baud_tick));
    a_r10_idle_when_off: assert property (@(posedge clk) disable iff (rst)
        $past(left_q == '0 && !tx_en) |-> txd_q);
    a_r6_frame_bound: assert property (@(posedge clk) disable iff (rst)
        left_q <= CW'(FW - 1));
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
    import uart_tx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          baud_tick,
    input  logic          tx_en,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          mp_mode,
    input  logic          len8,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          adr_bit,
    input  logic          tie,
    output logic          txd,
    output logic          tdre,
    output logic          tx_irq
);
    logic          full;
    logic [DW-1:0] hdata;
    logic          take;
    tx_cfg_t       cfg;

    assign cfg = '{mp: mp_mode, len8: len8, par_en: par_en, par_odd: par_odd};

    uart_tx_holdreg #(.WIDTH(DW)) u_hold (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .take(take), .full(full), .data(hdata)
    );

    uart_tx_shifter u_shift (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .tx_en(tx_en),
        .held(full), .held_data(hdata), .cfg(cfg), .adr_bit(adr_bit),
        .take(take), .txd(txd)
    );

    assign tdre   = !full;
    assign tx_irq = tdre && tie;

    a_r2_write_empties: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en) |-> !tdre);
    a_r7_empty_with_start: assert property (@(posedge clk) disable iff (rst)
        $rose(tdre) |-> !txd);
endmodule

// File: tb/sim_uart_tx_hold.sv
module sim_uart_tx_hold;
    localparam time PERIOD = 10ns;
    localparam int NV = 7;
    // {data[7:0], len8, mp, par_en, par_odd, adr}
    localparam logic [12:0] VEC [NV] = '{
        {8'h4D, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'hB2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'hA5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'h37, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        {8'hC3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'h5A, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        {8'hFF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}
    };

    logic clk = 0, rst = 1, baud_tick = 0, tx_en = 0, wr_en = 0;
    logic [7:0] wr_data = '0;
    logic mp_mode = 0, len8 = 1, par_en = 0, par_odd = 0, adr_bit = 0, tie = 0;
    logic txd, tdre, tx_irq;
    int checks = 0, fails = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    uart_tx_hold u0 (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .tx_en(tx_en),
        .wr_en(wr_en), .wr_data(wr_data), .mp_mode(mp_mode), .len8(len8),
        .par_en(par_en), .par_odd(par_odd), .adr_bit(adr_bit), .tie(tie),
        .txd(txd), .tdre(tdre), .tx_irq(tx_irq)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        baud_tick = 1;
        @(negedge clk);
        baud_tick = 0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic write(input logic [7:0] d);
        wr_en = 1; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    function automatic logic exp_bit(input logic [12:0] v, input int k);
        logic [7:0] d; logic l8, mp, pe, po, ad;
        int nd, n;
        logic x;
        {d, l8, mp, pe, po, ad} = v;
        nd = (mp || l8) ? 8 : 7;
        n  = nd + 2 + ((mp || pe) ? 1 : 0);
        if (k == 0) return 1'b0;
        if (k <= nd) return d[k-1];
        if (k == nd + 1 && (mp || pe)) begin
            if (mp) return ad;
            x = 1'b0;
            for (int i = 0; i < nd; i++) x = x ^ d[i];
            return x ^ po;
        end
        if (k >= n) return 1'b1;
        return 1'b1;
    endfunction

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [12:0] v;
        @(negedge clk); @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 txd", txd, 1'b1);
        chk("R1 tdre", tdre, 1'b1);
        // R8 gating
        chk("R8 irq tie=0", tx_irq, 1'b0);
        tie = 1;
        #1 chk("R8 irq tie=1", tx_irq, 1'b1);
        tx_en = 1;

        // table walk: R3 R4 R5 R6 R7
        for (int j = 0; j < NV; j++) begin
            v = VEC[j];
            {len8, mp_mode, par_en, par_odd, adr_bit} = v[4:0];
            write(v[12:5]);
            chk("R2 tdre after write", tdre, 1'b0);
            chk("R8 irq low when full", tx_irq, 1'b0);
            tick();
            chk("R7 tdre at start", tdre, 1'b1);
            chk("R3 start bit", txd, exp_bit(v, 0));
            adr_bit = ~adr_bit; // R6: must not affect the running frame
            for (int k = 1; k < 13; k++) begin
                tick();
                chk("R3/R4/R5/R6 frame bit", txd, exp_bit(v, k));
            end
        end

        // R10 enable gating
        mp_mode = 0; len8 = 1; par_en = 0;
        tx_en = 0;
        write(8'h00);
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R10 txd held high", txd, 1'b1);
            chk("R10 byte still held", tdre, 1'b0);
        end
        tx_en = 1;
        tick();
        chk("R10 start after enable", txd, 1'b0);
        chk("R7 tdre after enable", tdre, 1'b1);
        for (int k = 1; k < 12; k++) tick();
        chk("R10 idle after frame", txd, 1'b1);

        // R9 back-to-back frames
        write(8'h0F);
        tick();
        chk("R9 first start", txd, 1'b0);
        write(8'hF0);
        chk("R2 second write", tdre, 1'b0);
        for (int k = 1; k <= 9; k++) begin
            tick();
            chk("R9 first frame bit", txd, (k <= 8) ? ((8'h0F >> (k-1)) & 1'b1) : 1'b1);
        end
        tick();
        chk("R9 next start no gap", txd, 1'b0);
        chk("R9 tdre at second start", tdre, 1'b1);
        for (int k = 1; k <= 9; k++) begin
            tick();
            chk("R9 second frame bit", txd, (k <= 8) ? ((8'hF0 >> (k-1)) & 1'b1) : 1'b1);
        end
        tick();
        chk("R9 idle after pair", txd, 1'b1);
        tie = 0;
        #1 chk("R8 irq off", tx_irq, 1'b0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule